// File: doc/BRIEF.md
# Byte-Rotating AES Substitution Unit

This block is a functional unit for a 32-bit processor datapath. It turns one register operand into a substituted word. It first rotates the operand left by a whole number of bytes, from zero to three. It then passes every byte of the rotated word through the forward AES substitution box. The word that results is held in a register for write-back.

One unit covers two tasks without a second copy of the substitution logic:

- **Round encryption (SubBytes):** an amount of zero substitutes the word in place. Other amounts move a chosen byte into a lane before the substitution.
- **Key expansion:** an amount of one performs the rotate-then-substitute step of key expansion in a single operation.

The issue port has no handshake. An issue is accepted when `issue_valid` is high and `issue_op` equals the unit's own opcode. The result appears on the next clock, with a one-cycle `result_valid` strobe.

Top module: `aes_rot_sbox_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the edge sets `result` to 0 and `result_valid` to 0.
- R2: An accepted issue rotates `operand` left by 8×`rot_amt` bits before substitution. Byte lane 3 is bits 31:24 and is the most significant lane. Byte lane k of the rotated word is byte lane (k − `rot_amt`) mod 4 of the operand.
- R3: Each byte of the rotated word is replaced by its forward AES S-box value. That value is the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapping to 0, followed by the AES affine transform with constant 0x63. For example, 0x00 maps to 0x63 and 0x53 maps to 0xED.
- R4: All four byte lanes are substituted independently, within the same issue. Each lane's output depends only on the byte that the rotation routes to that lane.
- R5: An accepted issue sets `result_valid` high exactly one clock after the issue edge and `result` to the new word. If no issue is accepted at the next edge, `result_valid` returns low.
- R6: Issues accepted on consecutive clocks each produce their own correct result on consecutive clocks, with `result_valid` held high.
- R7: An issue with `issue_valid` high but `issue_op` not equal to `UNIT_OPCODE` (default 4'hA) is ignored. `result_valid` is low after that edge and `result` keeps its previous value.
- R8: When `issue_valid` is low, `result_valid` is low after the edge and `result` keeps its previous value.
- R9: With `rot_amt` = 1, the unit performs the key-expansion step. For example, operand 0x09CF4F3C gives 0x8A84EB01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| issue_op | input | OP_W (4) | Opcode. The issue is accepted only when this equals UNIT_OPCODE |
| operand | input | DATA_W (32) | Source register value |
| rot_amt | input | ROT_W (2) | Left rotation amount, in bytes |
| result | output | DATA_W (32) | Registered rotated-and-substituted word |
| result_valid | output | 1 | High for one cycle for each accepted issue |

## Verification
The hardest case to reach from the ports is the interaction of the rotation and the lanes. Each of the 256 byte values must reach every lane under every rotation amount, and must do so while issues arrive back to back. The bench gets there with a sweep of all byte values crossed with all four rotation amounts. Each operand carries four different byte patterns derived from the swept value, so every lane sees the full byte range under every rotation. The issues are driven on consecutive cycles with no gaps, so the registered output also changes on every clock throughout the sweep.

// File: rtl/aes_sbox_pkg.sv
package aes_sbox_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;
  localparam logic [BYTE_W-1:0] POLY_LOW = 8'h1B;

  // Multiply two field elements modulo x^8+x^4+x^3+x+1.
  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[BYTE_W-1] ? ((sh << 1) ^ POLY_LOW) : (sh << 1);
    end
    return acc;
  endfunction

  // Inverse as x^254 by repeated squaring; zero stays zero.
  function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] p;
    logic [BYTE_W-1:0] r;
    p = x;
    r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] v, input int k);
    return (v << k) | (v >> (BYTE_W - k));
  endfunction

  function automatic logic [BYTE_W-1:0] sbox_fwd(input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] b;
    b = gf_inv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ AFFINE_C;
  endfunction

endpackage

// File: rtl/aes_byte_rotl.sv
module aes_byte_rotl #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW    = LANES * BYTE_W,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DW-1:0]    din,
  input  logic [SEL_W-1:0] amt,
  output logic [DW-1:0]    dout
);

  logic [2*DW-1:0] dbl;
  logic [DW-1:0]   cand [LANES];

  assign dbl = {din, din};

  for (genvar s = 0; s < LANES; s++) begin : g_rot
    assign cand[s] = dbl[2*DW-1-s*BYTE_W -: DW];
  end

  always_comb begin
    dout = cand[0];
    for (int s = 0; s < LANES; s++) begin
      if (amt == SEL_W'(s)) dout = cand[s];
    end
  end

endmodule

// File: rtl/aes_sbox_lane.sv
module aes_sbox_lane
  import aes_sbox_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);

  always_comb dout = sbox_fwd(din);

endmodule

// File: rtl/aes_rot_sbox_unit.sv
module aes_rot_sbox_unit #(
  parameter int              DATA_W      = 32,
  parameter int              OP_W        = 4,
  parameter logic [OP_W-1:0] UNIT_OPCODE = 4'hA,
  localparam int             LANES       = DATA_W / aes_sbox_pkg::BYTE_W,
  localparam int             ROT_W       = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [OP_W-1:0]   issue_op,
  input  logic [DATA_W-1:0] operand,
  input  logic [ROT_W-1:0]  rot_amt,
  output logic [DATA_W-1:0] result,
  output logic              result_valid
);
  localparam int BW = aes_sbox_pkg::BYTE_W;

  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] substituted;
  logic              accept;

  assign accept = issue_valid && (issue_op == UNIT_OPCODE);

  aes_byte_rotl #(.LANES(LANES), .BYTE_W(BW)) u_rot (
    .din (operand),
    .amt (rot_amt),
    .dout(rotated)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    aes_sbox_lane u_sbox (
      .din (rotated[k*BW +: BW]),
      .dout(substituted[k*BW +: BW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= accept;
      if (accept) result <= substituted;
    end
  end

endmodule

// File: rtl/aes_rot_sbox_unit_chk.sv
module aes_rot_sbox_unit_chk #(
  parameter int              DATA_W      = 32,
  parameter int              OP_W        = 4,
  parameter logic [OP_W-1:0] UNIT_OPCODE = 4'hA,
  parameter int              ROT_W       = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_valid,
  input logic [OP_W-1:0]   issue_op,
  input logic [DATA_W-1:0] operand,
  input logic [ROT_W-1:0]  rot_amt,
  input logic [DATA_W-1:0] result,
  input logic              result_valid
);

  logic acc;
  assign acc = issue_valid && (issue_op == UNIT_OPCODE);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (result == '0 && !result_valid));

  assert_valid_after_issue_R5: assert property (@(posedge clk) disable iff (rst)
    acc |=> result_valid);

  assert_foreign_op_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_op != UNIT_OPCODE) |=> (!result_valid && $stable(result)));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> (!result_valid && $stable(result)));

  assert_zero_word_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && operand == '0) |=> (result == {(DATA_W/8){8'h63}}));

endmodule

bind aes_rot_sbox_unit aes_rot_sbox_unit_chk #(
  .DATA_W(DATA_W), .OP_W(OP_W), .UNIT_OPCODE(UNIT_OPCODE), .ROT_W(ROT_W)
) u_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
  .operand(operand), .rot_amt(rot_amt), .result(result), .result_valid(result_valid)
);

// File: tb/sim_aes_rot_sbox_unit.sv
module sim_aes_rot_sbox_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [3:0]  issue_op = 4'h0;
  logic [31:0] operand = '0;
  logic [1:0]  rot_amt = '0;
  logic [31:0] result;
  logic        result_valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  int exp_t [256];
  int log_t [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_rot_sbox_unit u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
    .operand(operand), .rot_amt(rot_amt), .result(result), .result_valid(result_valid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual cycles=%0d expected < %0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int xt(int v);
    return ((v << 1) ^ (((v >> 7) & 1) != 0 ? 'h11B : 0)) & 'hFF;
  endfunction

  // Inverse via discrete logs to base 3, then affine by bit formula.
  function automatic logic [7:0] ref_sbox(logic [7:0] x);
    logic [7:0] b;
    logic [7:0] s;
    b = (x == 0) ? 8'h00 : 8'(exp_t[(255 - log_t[x]) % 255]);
    for (int i = 0; i < 8; i++)
      s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return s;
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] w, int r);
    logic [31:0] o;
    for (int k = 0; k < 4; k++)
      o[k*8 +: 8] = ref_sbox(w[((k - r + 4) % 4)*8 +: 8]);
    return o;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(bit v, logic [3:0] op, logic [31:0] w, int r);
    issue_valid = v;
    issue_op    = op;
    operand     = w;
    rot_amt     = 2'(r);
  endtask

  initial begin
    int e;
    logic [31:0] last;
    e = 1;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = e;
      log_t[e] = i;
      e = e ^ xt(e);
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset result", result, 32'h0);
    check("R1 reset valid", {31'b0, result_valid}, 32'h0);

    @(negedge clk);
    check("R8 idle valid", {31'b0, result_valid}, 32'h0);

    // Sweep every byte value under every rotation, back to back.
    for (int v = 0; v < 256; v++) begin
      for (int r = 0; r < 4; r++) begin
        logic [31:0] w;
        w = {8'(v), 8'(v) ^ 8'h5A, 8'(v + 77), ~8'(v)};
        drive(1'b1, 4'hA, w, r);
        @(negedge clk);
        check("R2 R3 R4 R6 sweep", result, ref_word(w, r));
        check("R6 valid held", {31'b0, result_valid}, 32'h1);
        last = result;
      end
    end

    // Wrong opcode: ignored.
    drive(1'b1, 4'h3, 32'hDEADBEEF, 1);
    @(negedge clk);
    check("R7 foreign op valid", {31'b0, result_valid}, 32'h0);
    check("R7 foreign op result", result, last);

    // Right opcode, valid low: ignored.
    drive(1'b0, 4'hA, 32'h12345678, 2);
    @(negedge clk);
    check("R8 idle result", result, last);
    check("R8 idle valid", {31'b0, result_valid}, 32'h0);

    // Fixed values: R3 known bytes, for each rotation.
    for (int r = 0; r < 4; r++) begin
      drive(1'b1, 4'hA, 32'h53000000, r);
      @(negedge clk);
      check("R3 S(53)=ED S(00)=63", result,
            (32'hED636363 << (8*r)) | (32'hED636363 >> ((32 - 8*r) % 32) & ((r == 0) ? 32'h0 : 32'hFFFFFFFF)));
    end

    // Key-expansion step.
    drive(1'b1, 4'hA, 32'h09CF4F3C, 1);
    @(negedge clk);
    check("R9 key step", result, 32'h8A84EB01);

    // Single issue then idle: strobe lasts one cycle.
    drive(1'b0, 4'hA, 32'h0, 0);
    @(negedge clk);
    drive(1'b1, 4'hA, 32'h00000053, 0);
    @(negedge clk);
    check("R5 valid after one clock", {31'b0, result_valid}, 32'h1);
    check("R5 result", result, 32'h636363ED);
    drive(1'b0, 4'hA, 32'h0, 0);
    @(negedge clk);
    check("R5 valid drops", {31'b0, result_valid}, 32'h0);
    check("R5 result held", result, 32'h636363ED);

    // Reset mid-run clears state.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset after use", result, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule